// File: doc/BRIEF.md
# DRAM Bank Write-Auto-Precharge Timing Tracker

This block sits on the controller side of a DRAM interface and follows the timing of one bank. It watches two decoded command strobes, activate and write. A write carries a one-bit auto-precharge request. The block reports when the bank may be opened again. It also marks the cycle in which the device begins its internal precharge, and says whether a write-with-precharge sequence is still running. All times are whole clock cycles. The write latency is taken as one cycle less than the configured read latency. A data burst of BL beats occupies BL/2 clock cycles, because data moves on both clock edges.

Two independent limits gate a new activate, and the later of the two governs. The first limit counts from the write: write latency, then the burst, then write recovery, then row precharge. The second is the row cycle time, counted from the last accepted activate. An activate issued while the bank is not ready is reported as a protocol error and otherwise ignored. The configuration inputs are sampled when a command is accepted, so they may change freely while a sequence runs.

Cycle convention used below. A command is sampled at rising edge k. An output is said to be "at cycle k+n" when it holds its value just before rising edge k+n, so a command issued at edge k+n sees that value. RL is at least 2, BL is at least 2 and tRP is at least 1. Smaller values are raised to these floors inside the block.

Top module: `dram_wap_tracker`

## Requirements
- R1: After reset, act_ready_o is 1 and busy_o, pre_start_o and proto_err_o are 0. The first activate is accepted at once, without an error.
- R2: A write with ap_i = 0 has no effect. No precharge pulse follows, busy_o stays 0, and act_ready_o keeps the timing set by the row cycle limit alone.
- R3: A write with ap_i = 1 accepted at edge W drives pre_start_o high for exactly one cycle, at cycle W + (RL-1) + BL/2 + tWR.
- R4: After that write, act_ready_o stays 0 until cycle W + (RL-1) + BL/2 + tWR + tRP.
- R5: An activate accepted at edge A holds act_ready_o at 0 until cycle A + tRC. act_ready_o is 1 only when both the R4 limit and the R5 limit are met.
- R6: busy_o is 1 from cycle W+1 until the R4 limit is met, and is 0 at that cycle.
- R7: An activate while act_ready_o is 0 makes proto_err_o 1 for one cycle, in the next cycle. It does not restart the row cycle count.
- R8: RL, BL, tWR and tRP are captured at the accepted write, and tRC is captured at the accepted activate. Later changes do not affect the running sequence.
- R9: A write with ap_i = 1 that arrives while busy_o is 1 is ignored. The pulse and ready cycles of the running sequence do not move.
- R10: Configuration RL=3, BL=4, tWR=2, tRP=3, tRC=12, with the write one cycle after the activate: ready comes 11 cycles after the write, where tRC is the limit. Configuration RL=5, BL=4, tWR=2, tRP=3, tRC=12, with the write two cycles after the activate: ready comes 11 cycles after the write, where write recovery plus precharge is the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_i | input | 1 | Activate command strobe |
| wr_i | input | 1 | Write command strobe |
| ap_i | input | 1 | Auto-precharge request bit of the write |
| cfg_rd_lat_i | input | CFG_W | Read latency in cycles (write latency = this - 1) |
| cfg_burst_len_i | input | CFG_W | Burst length in beats |
| cfg_wr_rec_i | input | CFG_W | Write recovery time in cycles |
| cfg_row_pre_i | input | CFG_W | Row precharge time in cycles |
| cfg_row_cyc_i | input | CFG_W | Row cycle time in cycles |
| act_ready_o | output | 1 | Bank may be activated in this cycle |
| pre_start_o | output | 1 | One-cycle mark of the start of auto-precharge |
| busy_o | output | 1 | Write-with-precharge sequence still running |
| proto_err_o | output | 1 | Activate was issued while not ready (one cycle, delayed) |

## Verification
Faults in the write sequencer's phase or count show up directly at the ports. A wrong count moves pre_start_o and the rise of act_ready_o off their computed cycles, and the shift is visible within one sequence, at most a few tens of cycles after the write. A stuck phase shows as busy_o never clearing, or as a second pulse. A wrong row cycle count or a missed error flag shows within tRC cycles of the activate, as an early or late ready rise or as a missing proto_err_o one cycle after a rejected activate. Every sequence is measured against cycle numbers the bench derives from the formulas, once in each limiting regime.

// File: rtl/dwt_pkg.sv
package dwt_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE     = 2'd0,
    SEQ_PRE_WAIT = 2'd1,
    SEQ_RP_WAIT  = 2'd2
  } seq_state_e;

endpackage

// File: rtl/dwt_rst_sync.sv
module dwt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;

endmodule

// File: rtl/dwt_len_calc.sv
module dwt_len_calc #(
  parameter int CFG_W = 6,
  parameter int CNT_W = CFG_W + 2
) (
  input  logic [CFG_W-1:0] rd_lat_i,
  input  logic [CFG_W-1:0] burst_len_i,
  input  logic [CFG_W-1:0] wr_rec_i,
  input  logic [CFG_W-1:0] row_pre_i,
  output logic [CNT_W-1:0] pre_len_o,
  output logic [CNT_W-1:0] rp_len_o
);

  logic [CNT_W-1:0] wl_ext;
  logic [CNT_W-1:0] burst_cyc;
  logic [CNT_W-1:0] rec_ext;
  logic [CNT_W-1:0] sum;

  always_comb begin
    // write latency is one below read latency, never below 1
    if (rd_lat_i > CFG_W'(2)) begin
      wl_ext = CNT_W'(rd_lat_i) - CNT_W'(1);
    end else begin
      wl_ext = CNT_W'(1);
    end
    // double data rate: BL beats take BL/2 clocks, at least 1
    if (burst_len_i > CFG_W'(3)) begin
      burst_cyc = CNT_W'(burst_len_i >> 1);
    end else begin
      burst_cyc = CNT_W'(1);
    end
    rec_ext = CNT_W'(wr_rec_i);
    sum     = wl_ext + burst_cyc + rec_ext;
    pre_len_o = sum;
    if (row_pre_i == '0) begin
      rp_len_o = CNT_W'(1);
    end else begin
      rp_len_o = CNT_W'(row_pre_i);
    end
  end

endmodule

// File: rtl/dwt_wr_seq.sv
module dwt_wr_seq
  import dwt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] pre_len_i,
  input  logic [CNT_W-1:0] rp_len_i,
  output logic             pre_pulse_o,
  output logic             clear_o
);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] rp_q, rp_d;
  logic             cnt_zero;
  logic             upd_en;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    rp_d    = rp_q;
    unique case (state_q)
      SEQ_IDLE: begin
        if (start_i) begin
          state_d = SEQ_PRE_WAIT;
          cnt_d   = pre_len_i - CNT_W'(1);
          rp_d    = rp_len_i;
        end
      end
      SEQ_PRE_WAIT: begin
        if (cnt_zero) begin
          state_d = SEQ_RP_WAIT;
          cnt_d   = rp_q - CNT_W'(1);
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      SEQ_RP_WAIT: begin
        if (cnt_zero) begin
          if (start_i) begin
            state_d = SEQ_PRE_WAIT;
            cnt_d   = pre_len_i - CNT_W'(1);
            rp_d    = rp_len_i;
          end else begin
            state_d = SEQ_IDLE;
          end
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      default: begin
        state_d = SEQ_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  assign upd_en = (state_q != SEQ_IDLE) || start_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      rp_q    <= '0;
    end else if (upd_en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rp_q    <= rp_d;
    end
  end

  assign pre_pulse_o = (state_q == SEQ_PRE_WAIT) && cnt_zero;
  assign clear_o     = (state_q == SEQ_IDLE) ||
                       ((state_q == SEQ_RP_WAIT) && cnt_zero);

endmodule

// File: rtl/dwt_rc_timer.sv
module dwt_rc_timer #(
  parameter int CFG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CFG_W-1:0] len_i,
  output logic             ready_o
);

  logic [CFG_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    if (start_i) begin
      cnt_d = (len_i == '0) ? '0 : len_i - CFG_W'(1);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CFG_W'(1);
    end
  end

  assign cnt_en = start_i || (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign ready_o = (cnt_q == '0);

endmodule

// File: rtl/dram_wap_tracker.sv
module dram_wap_tracker #(
  parameter int CFG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_i,
  input  logic             wr_i,
  input  logic             ap_i,
  input  logic [CFG_W-1:0] cfg_rd_lat_i,
  input  logic [CFG_W-1:0] cfg_burst_len_i,
  input  logic [CFG_W-1:0] cfg_wr_rec_i,
  input  logic [CFG_W-1:0] cfg_row_pre_i,
  input  logic [CFG_W-1:0] cfg_row_cyc_i,
  output logic             act_ready_o,
  output logic             pre_start_o,
  output logic             busy_o,
  output logic             proto_err_o
);

  localparam int CNT_W = CFG_W + 2;

  logic             rst_core_n;
  logic [CNT_W-1:0] pre_len;
  logic [CNT_W-1:0] rp_len;
  logic             wr_clear;
  logic             rc_ready;
  logic             act_take;
  logic             wap_take;
  logic             err_q, err_d;

  dwt_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  dwt_len_calc #(.CFG_W(CFG_W), .CNT_W(CNT_W)) u_len_calc (
    .rd_lat_i    (cfg_rd_lat_i),
    .burst_len_i (cfg_burst_len_i),
    .wr_rec_i    (cfg_wr_rec_i),
    .row_pre_i   (cfg_row_pre_i),
    .pre_len_o   (pre_len),
    .rp_len_o    (rp_len)
  );

  assign wap_take = wr_i && ap_i && wr_clear;
  assign act_take = act_i && act_ready_o;

  dwt_wr_seq #(.CNT_W(CNT_W)) u_wr_seq (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .start_i     (wap_take),
    .pre_len_i   (pre_len),
    .rp_len_i    (rp_len),
    .pre_pulse_o (pre_start_o),
    .clear_o     (wr_clear)
  );

  dwt_rc_timer #(.CFG_W(CFG_W)) u_rc_timer (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .start_i (act_take),
    .len_i   (cfg_row_cyc_i),
    .ready_o (rc_ready)
  );

  assign act_ready_o = wr_clear && rc_ready;
  assign busy_o      = !wr_clear;

  assign err_d = act_i && !act_ready_o;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end

  assign proto_err_o = err_q;

endmodule

// File: rtl/dwt_tracker_chk.sv
module dwt_tracker_chk (
  input logic clk,
  input logic rst_n,
  input logic act_i,
  input logic wr_i,
  input logic ap_i,
  input logic act_ready_o,
  input logic pre_start_o,
  input logic busy_o,
  input logic proto_err_o
);

  assert_pre_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pre_start_o |=> !pre_start_o);

  assert_err_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err_o |-> ($past(act_i) && !$past(act_ready_o)));

  assert_plain_wr_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !ap_i && !busy_o) |=> !busy_o);

  assert_pre_in_seq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pre_start_o |-> (busy_o && !act_ready_o));

  assert_ready_after_seq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_ready_o) |-> !busy_o);

endmodule

bind dram_wap_tracker dwt_tracker_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .act_i       (act_i),
  .wr_i        (wr_i),
  .ap_i        (ap_i),
  .act_ready_o (act_ready_o),
  .pre_start_o (pre_start_o),
  .busy_o      (busy_o),
  .proto_err_o (proto_err_o)
);

// File: tb/dram_wap_tracker_bench.sv
module dram_wap_tracker_bench;

  localparam int CFG_W = 6;
  localparam int NVEC  = 5;
  // rl, bl, twr, trp, trc, gap(act->write), exp_pre, exp_rdy (both from write)
  localparam int VEC [NVEC][8] = '{
    '{3, 4, 2, 3, 12, 1,  6, 11},
    '{5, 4, 2, 3, 12, 2,  8, 11},
    '{3, 8, 1, 2,  4, 1,  7,  9},
    '{2, 4, 0, 1, 20, 3,  3, 17},
    '{4, 8, 3, 4,  6, 1, 10, 14}
  };

  logic clk;
  logic rst_n;
  logic act_i, wr_i, ap_i;
  logic [CFG_W-1:0] cfg_rl, cfg_bl, cfg_twr, cfg_trp, cfg_trc;
  logic act_ready_o, pre_start_o, busy_o, proto_err_o;

  int n_chk;
  int n_bad;

  dram_wap_tracker #(.CFG_W(CFG_W)) u_dram_wap_tracker (
    .clk             (clk),
    .rst_n           (rst_n),
    .act_i           (act_i),
    .wr_i            (wr_i),
    .ap_i            (ap_i),
    .cfg_rd_lat_i    (cfg_rl),
    .cfg_burst_len_i (cfg_bl),
    .cfg_wr_rec_i    (cfg_twr),
    .cfg_row_pre_i   (cfg_trp),
    .cfg_row_cyc_i   (cfg_trc),
    .act_ready_o     (act_ready_o),
    .pre_start_o     (pre_start_o),
    .busy_o          (busy_o),
    .proto_err_o     (proto_err_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic next_cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 200; i++) begin
      if (act_ready_o) break;
      next_cyc();
    end
  endtask

  task automatic set_wcfg(input int rl, input int bl, input int twr, input int trp);
    cfg_rl  = CFG_W'(rl);
    cfg_bl  = CFG_W'(bl);
    cfg_twr = CFG_W'(twr);
    cfg_trp = CFG_W'(trp);
  endtask

  // Watches cycles start_n..max_n; optionally issues a write-AP at inj_n
  task automatic watch(input int start_n, input int max_n, input int inj_n,
                       input int probe_n,
                       output int pre_first, output int pre_cnt,
                       output int rdy_first, output int probe_busy,
                       output int busy_seen);
    pre_first  = -1;
    pre_cnt    = 0;
    rdy_first  = -1;
    probe_busy = -1;
    busy_seen  = 0;
    for (int n = start_n; n <= max_n; n++) begin
      if (pre_start_o) begin
        pre_cnt++;
        if (pre_first < 0) pre_first = n;
      end
      if (act_ready_o && rdy_first < 0) rdy_first = n;
      if (busy_o) busy_seen = 1;
      if (n == probe_n) probe_busy = int'(busy_o);
      if (n == inj_n) begin
        wr_i = 1'b1;
        ap_i = 1'b1;
        set_wcfg(5, 8, 4, 5);
      end
      next_cyc();
      wr_i = 1'b0;
      ap_i = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int pf, pc, rf, pb, bs;
    n_chk = 0;
    n_bad = 0;
    rst_n = 1'b0;
    act_i = 1'b0;
    wr_i  = 1'b0;
    ap_i  = 1'b0;
    set_wcfg(3, 4, 2, 3);
    cfg_trc = CFG_W'(10);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) next_cyc();

    // R1: reset state
    chk("R1 ready after reset", int'(act_ready_o), 1);
    chk("R1 busy after reset", int'(busy_o), 0);
    chk("R1 pre after reset", int'(pre_start_o), 0);
    chk("R1 err after reset", int'(proto_err_o), 0);

    // R1/R5: first activate accepted, trc=10
    act_i = 1'b1;
    next_cyc();
    act_i = 1'b0;
    chk("R1 first activate no error", int'(proto_err_o), 0);
    chk("R5 ready low after activate", int'(act_ready_o), 0);
    // R7: rejected activate at cycle A+2
    next_cyc();
    act_i = 1'b1;
    next_cyc();
    act_i = 1'b0;
    chk("R7 error after rejected activate", int'(proto_err_o), 1);
    next_cyc();
    chk("R7 error lasts one cycle", int'(proto_err_o), 0);
    watch(4, 16, 0, 0, pf, pc, rf, pb, bs);
    chk("R7 rejected activate keeps tRC (ready cycle)", rf, 10);
    chk("R5 no precharge without write", pc, 0);

    // Table of sequences: R3 R4 R5 R6 R8 R10
    for (int v = 0; v < NVEC; v++) begin
      wait_ready();
      cfg_trc = CFG_W'(VEC[v][4]);
      act_i = 1'b1;
      next_cyc();
      act_i = 1'b0;
      cfg_trc = '1;  // R8: later tRC change has no effect
      for (int g = 1; g < VEC[v][5]; g++) next_cyc();
      set_wcfg(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
      wr_i = 1'b1;
      ap_i = 1'b1;
      next_cyc();
      wr_i = 1'b0;
      ap_i = 1'b0;
      set_wcfg(63, 62, 63, 63);  // R8: change while the sequence runs
      chk($sformatf("R6 busy after write v%0d", v), int'(busy_o), 1);
      watch(1, 40, 0, VEC[v][6] + VEC[v][3], pf, pc, rf, pb, bs);
      chk($sformatf("R3 pre pulse cycle v%0d", v), pf, VEC[v][6]);
      chk($sformatf("R3 single pulse v%0d", v), pc, 1);
      chk($sformatf("R4 R5 R8 R10 ready cycle v%0d", v), rf, VEC[v][7]);
      chk($sformatf("R6 busy clear at limit v%0d", v), pb, 0);
    end

    // R2: plain write changes nothing
    wait_ready();
    cfg_trc = CFG_W'(3);
    act_i = 1'b1;
    next_cyc();
    act_i = 1'b0;
    set_wcfg(3, 4, 2, 3);
    wr_i = 1'b1;
    ap_i = 1'b0;
    next_cyc();
    wr_i = 1'b0;
    watch(2, 20, 0, 0, pf, pc, rf, pb, bs);
    chk("R2 plain write no pulse", pc, 0);
    chk("R2 plain write no busy", bs, 0);
    chk("R2 plain write ready at tRC", rf, 3);

    // R9: write-AP during a running sequence is ignored
    wait_ready();
    cfg_trc = CFG_W'(2);
    act_i = 1'b1;
    next_cyc();
    act_i = 1'b0;
    set_wcfg(3, 4, 2, 3);
    wr_i = 1'b1;
    ap_i = 1'b1;
    next_cyc();
    wr_i = 1'b0;
    ap_i = 1'b0;
    watch(1, 30, 3, 0, pf, pc, rf, pb, bs);
    chk("R9 pulse cycle unchanged", pf, 6);
    chk("R9 single pulse", pc, 1);
    chk("R9 ready cycle unchanged", rf, 9);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule